// File: doc/BRIEF.md
# Variable-Advance Digit-Recurrence Step Controller

This block decides, once per iteration of a high-radix digit-recurrence divider, how far the quotient moves forward. Two digit guesses are presented every cycle. One is for a whole radix-16 digit and the other is for a two-bit step. Each comes with the truncated residual estimate it would produce. The block compares the magnitude of the full-digit residual estimate with two bounds derived from the divisor estimate, and it picks one of three outcomes:

- **Full advance:** the residual is inside the convergence bound.
- **Partial advance:** the residual is outside that bound but inside a bound four times wider.
- **No advance:** the residual is beyond both bounds, and the cycle becomes a correction.

The chosen outcome drives a multiplexer. The multiplexer emits the selected digit, the quotient shift and the residual for the next iteration. A wide two's-complement quotient register is shifted by the selected amount and the signed digit is added to it. A partial digit therefore lands overlapping the previous digit instead of after it. A counter of advanced bits plays the role of the sliding digit weight. Once the counter reaches the target precision, the block reports completion and ignores further steps. The block also keeps one counter per outcome for statistics. The speculation tables and the carry-save residual array sit outside this block.

Top module: `vadv_ctrl`

## Requirements
- R1: After reset the quotient register, the advanced-bit count, the done flag and all three outcome counters read zero.
- R2: With the bound B = (d_est·RHO_NUM)>>RHO_SHIFT (B = d_est by default), |w_full| ≤ B selects full advance. Full advance gives code 2'b01, shift 4, digit q_full and next residual w_full.
- R3: B < |w_full| ≤ 4·B selects partial advance. Partial advance gives code 2'b10, shift 2, digit q_part and next residual w_part.
- R4: |w_full| > 4·B selects no advance. No advance gives code 2'b00 and shift 0. Its correction digit is +2 when w_full ≥ 0 and −2 otherwise, and its next residual is w_full − digit·d_est.
- R5: On an accepted step the quotient becomes Q·2^shift + digit, with the digit sign-extended and the result kept modulo 2^64. The advanced-bit count grows by the shift.
- R6: When step_en is low, the quotient, the bit count and the counters keep their values.
- R7: done is high exactly when the bit count is at least 54. The count may overshoot 54 by up to 3 bits. While done is high, steps change neither the quotient, nor the count, nor the counters.
- R8: start clears the quotient, the count and the counters, and it takes priority over step_en.
- R9: Each accepted step adds one to the counter of its outcome (cnt_full, cnt_part or cnt_none) and leaves the other two counters unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Clear state for a new operation |
| step_en | input | 1 | Iteration valid this cycle |
| w_full | input | 12 | Signed residual estimate after the full-digit guess |
| w_part | input | 12 | Signed residual estimate after the two-bit guess |
| d_est | input | 8 | Unsigned divisor estimate |
| q_full | input | 6 | Signed full-digit guess |
| q_part | input | 6 | Signed two-bit-step guess |
| outcome | output | 2 | 00 none, 01 full, 10 partial |
| shift_amt | output | 3 | Quotient shift this cycle |
| q_sel | output | 6 | Signed digit accumulated this cycle |
| w_next | output | 22 | Signed selected residual for the next iteration |
| quotient | output | 64 | Accumulated quotient register |
| bits_done | output | 6 | Advanced bit count |
| done | output | 1 | Target precision reached |
| cnt_full | output | 16 | Full-advance count |
| cnt_part | output | 16 | Partial-advance count |
| cnt_none | output | 16 | No-advance count |

## Verification
The outcome code, shift, selected digit and next residual are combinational, so they are due in the same cycle as the inputs. The bench drives the inputs on the falling edge and samples these outputs one nanosecond later, before the next rising edge. The quotient, the bit count, done and the counters change on the rising edge that accepts a step, so they are due one cycle after the stimulus. The bench samples them one nanosecond after that edge and compares them with a model it advances at the same point. Directed cases hit each bound exactly and one unit beyond it, with both signs of residual. Other directed cases cover overshoot past the target and steps during done and during start.

// File: rtl/vadv_pkg.sv
// Shared types for the variable-advance step controller.
package vadv_pkg;
    // Per-cycle advance decision; the encoding is visible at the ports.
    typedef enum logic [1:0] {
        ADV_NONE = 2'b00,
        ADV_FULL = 2'b01,
        ADV_PART = 2'b10
    } adv_e;
endpackage

// File: rtl/vadv_classify.sv
// Bound comparison: classifies the full-digit residual estimate against the
// convergence bound B and the widened bound B << GAP.
// Assumes d_est is an unsigned truncated divisor and w_full a signed estimate.
module vadv_classify
    import vadv_pkg::*;
#(
    parameter int W_W       = 12,
    parameter int D_W       = 8,
    parameter int GAP       = 2,
    parameter int RHO_NUM   = 1,
    parameter int RHO_SHIFT = 0
) (
    input  logic signed [W_W-1:0] w_full,
    input  logic        [D_W-1:0] d_est,
    output adv_e                  outcome,
    output logic                  w_neg
);
    localparam int RHO_W = $clog2(RHO_NUM + 1);
    localparam int B_W   = D_W + RHO_W + GAP;
    localparam int CMP_W = (W_W + 1 > B_W) ? W_W + 1 : B_W;

    logic signed [W_W:0]   w_ext;
    logic        [CMP_W-1:0] mag;
    logic        [B_W-1:0]   prod;
    logic        [B_W-1:0]   bound_full;
    logic        [B_W-1:0]   bound_part;

    // Magnitude of the residual estimate, one bit wider to hold the most negative value.
    always_comb begin
        w_ext = (W_W + 1)'(w_full);
        if (w_ext < 0) mag = CMP_W'(unsigned'(-w_ext));
        else           mag = CMP_W'(unsigned'(w_ext));
    end

    // Scaled bounds derived from the divisor estimate.
    always_comb begin
        prod       = B_W'(d_est) * B_W'(RHO_NUM);
        bound_full = prod >> RHO_SHIFT;
        bound_part = bound_full << GAP;
    end

    // Three-way decision: full, partial or no advance.
    always_comb begin
        if (mag <= CMP_W'(bound_full))      outcome = ADV_FULL;
        else if (mag <= CMP_W'(bound_part)) outcome = ADV_PART;
        else                                outcome = ADV_NONE;
    end

    assign w_neg = w_full[W_W-1];
endmodule

// File: rtl/vadv_select.sv
// Outcome multiplexer: picks digit, shift and next residual for the cycle.
// In a no-advance cycle it forms a correction digit of +/-2^(GAP-1)
// and applies it to the full-digit residual at the same weight.
module vadv_select
    import vadv_pkg::*;
#(
    parameter int W_W    = 12,
    parameter int D_W    = 8,
    parameter int QD_W   = 6,
    parameter int LOG2_R = 4,
    parameter int LOG2_P = 2,
    parameter int RES_W  = 22,
    parameter int SH_W   = 3
) (
    input  adv_e                    outcome,
    input  logic                    w_neg,
    input  logic signed [W_W-1:0]   w_full,
    input  logic signed [W_W-1:0]   w_part,
    input  logic        [D_W-1:0]   d_est,
    input  logic signed [QD_W-1:0]  q_full,
    input  logic signed [QD_W-1:0]  q_part,
    output logic signed [QD_W-1:0]  q_sel,
    output logic        [SH_W-1:0]  shift_amt,
    output logic signed [RES_W-1:0] w_next
);
    localparam int GAP      = LOG2_R - LOG2_P;
    localparam int CORR_LOG = (GAP > 0) ? GAP - 1 : 0;

    logic signed [QD_W-1:0]  q_corr;
    logic signed [RES_W-1:0] wf_x;
    logic signed [RES_W-1:0] wp_x;
    logic signed [RES_W-1:0] d_corr;
    logic signed [RES_W-1:0] w_corr;

    // Correction digit and the residual it produces.
    always_comb begin
        wf_x   = RES_W'(w_full);
        wp_x   = RES_W'(w_part);
        d_corr = $signed(RES_W'(d_est) << CORR_LOG);
        if (w_neg) begin
            q_corr = -QD_W'(1 << CORR_LOG);
            w_corr = wf_x + d_corr;
        end else begin
            q_corr = QD_W'(1 << CORR_LOG);
            w_corr = wf_x - d_corr;
        end
    end

    // Route the chosen outcome to the outputs.
    always_comb begin
        unique case (outcome)
            ADV_FULL: begin
                q_sel = q_full; shift_amt = SH_W'(LOG2_R); w_next = wf_x;
            end
            ADV_PART: begin
                q_sel = q_part; shift_amt = SH_W'(LOG2_P); w_next = wp_x;
            end
            default: begin
                q_sel = q_corr; shift_amt = '0; w_next = w_corr;
            end
        endcase
    end
endmodule

// File: rtl/vadv_accum.sv
// Quotient accumulator with variable shift and advanced-bit counter.
// Assumes the shift never exceeds LOG2_R and that accept is already
// qualified by done and start at the top level.
module vadv_accum #(
    parameter int QD_W        = 6,
    parameter int Q_W         = 64,
    parameter int SH_W        = 3,
    parameter int BIT_W       = 6,
    parameter int TARGET_BITS = 54
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   accept,
    input  logic                   step_en,
    input  logic        [SH_W-1:0] shift_amt,
    input  logic signed [QD_W-1:0] q_sel,
    output logic signed [Q_W-1:0]  quotient,
    output logic       [BIT_W-1:0] bits_done,
    output logic                   done
);
    // Quotient and bit-count state: clear on start, shift-and-add on accept.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            quotient  <= '0;
            bits_done <= '0;
        end else if (accept) begin
            quotient  <= (quotient <<< shift_amt) + Q_W'(q_sel);
            bits_done <= bits_done + BIT_W'(shift_amt);
        end
    end

    // Completion flag from the bit count.
    assign done = (bits_done >= BIT_W'(TARGET_BITS));

    a_r5_bits_grow: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> bits_done == $past(bits_done) + BIT_W'($past(shift_amt)));
    a_r6_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_en && !start) |=> ($stable(quotient) && $stable(bits_done)));
    a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(quotient)));
    a_r8_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (bits_done == '0 && quotient == '0));
endmodule

// File: rtl/vadv_stats.sv
// Outcome counters: one per advance kind, incremented on accepted steps.
// Assumes the outcome code is one of the three legal values.
module vadv_stats
    import vadv_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  accept,
    input  adv_e                  outcome,
    output logic [2:0][CNT_W-1:0] cnt
);
    for (genvar k = 0; k < 3; k++) begin : g_cnt
        // Counter for outcome code k.
        always_ff @(posedge clk) begin
            if (!rst_n || start)                      cnt[k] <= '0;
            else if (accept && outcome == adv_e'(k))  cnt[k] <= cnt[k] + 1'b1;
        end
    end

    a_r9_one_bump: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !start) |=> (cnt[0] + cnt[1] + cnt[2]) ==
            ($past(cnt[0]) + $past(cnt[1]) + $past(cnt[2]) + 1'b1));
    a_r9_no_bump: assert property (@(posedge clk) disable iff (!rst_n)
        (!accept && !start) |=> $stable(cnt));
endmodule

// File: rtl/vadv_ctrl.sv
// Top of the variable-advance step controller: classifies the speculative
// residual, selects full, partial or no advance, accumulates the quotient
// and counts outcomes. Assumes the estimates are presented with step_en.
module vadv_ctrl
    import vadv_pkg::*;
#(
    parameter int W_W         = 12,
    parameter int D_W         = 8,
    parameter int QD_W        = 6,
    parameter int LOG2_R      = 4,
    parameter int LOG2_P      = 2,
    parameter int RHO_NUM     = 1,
    parameter int RHO_SHIFT   = 0,
    parameter int TARGET_BITS = 54,
    parameter int CNT_W       = 16,
    localparam int RES_W      = W_W + D_W + 2,
    localparam int Q_W        = TARGET_BITS + LOG2_R + QD_W,
    localparam int BIT_W      = $clog2(TARGET_BITS + LOG2_R + 1),
    localparam int SH_W       = $clog2(LOG2_R + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    step_en,
    input  logic signed [W_W-1:0]   w_full,
    input  logic signed [W_W-1:0]   w_part,
    input  logic        [D_W-1:0]   d_est,
    input  logic signed [QD_W-1:0]  q_full,
    input  logic signed [QD_W-1:0]  q_part,
    output logic        [1:0]       outcome,
    output logic        [SH_W-1:0]  shift_amt,
    output logic signed [QD_W-1:0]  q_sel,
    output logic signed [RES_W-1:0] w_next,
    output logic signed [Q_W-1:0]   quotient,
    output logic        [BIT_W-1:0] bits_done,
    output logic                    done,
    output logic        [CNT_W-1:0] cnt_full,
    output logic        [CNT_W-1:0] cnt_part,
    output logic        [CNT_W-1:0] cnt_none
);
    localparam int GAP = LOG2_R - LOG2_P;

    adv_e                  adv;
    logic                  w_neg;
    logic                  accept;
    logic [2:0][CNT_W-1:0] cnt;

    vadv_classify #(.W_W(W_W), .D_W(D_W), .GAP(GAP),
                    .RHO_NUM(RHO_NUM), .RHO_SHIFT(RHO_SHIFT)) u_classify (
        .w_full(w_full), .d_est(d_est), .outcome(adv), .w_neg(w_neg));

    vadv_select #(.W_W(W_W), .D_W(D_W), .QD_W(QD_W), .LOG2_R(LOG2_R),
                  .LOG2_P(LOG2_P), .RES_W(RES_W), .SH_W(SH_W)) u_select (
        .outcome(adv), .w_neg(w_neg), .w_full(w_full), .w_part(w_part),
        .d_est(d_est), .q_full(q_full), .q_part(q_part),
        .q_sel(q_sel), .shift_amt(shift_amt), .w_next(w_next));

    // A step counts only while unfinished and not being restarted.
    assign accept = step_en && !done && !start;

    vadv_accum #(.QD_W(QD_W), .Q_W(Q_W), .SH_W(SH_W), .BIT_W(BIT_W),
                 .TARGET_BITS(TARGET_BITS)) u_accum (
        .clk(clk), .rst_n(rst_n), .start(start), .accept(accept),
        .step_en(step_en), .shift_amt(shift_amt), .q_sel(q_sel),
        .quotient(quotient), .bits_done(bits_done), .done(done));

    vadv_stats #(.CNT_W(CNT_W)) u_stats (
        .clk(clk), .rst_n(rst_n), .start(start), .accept(accept),
        .outcome(adv), .cnt(cnt));

    assign outcome  = adv;
    assign cnt_none = cnt[0];
    assign cnt_full = cnt[1];
    assign cnt_part = cnt[2];

    // R2/R4: shift and outcome code stay consistent across the multiplexer.
    a_r2_full_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (adv == ADV_FULL) |-> shift_amt == SH_W'(LOG2_R));
    a_r4_none_noshift: assert property (@(posedge clk) disable iff (!rst_n)
        (adv == ADV_NONE) |-> (shift_amt == '0 && q_sel != '0));
endmodule

// File: tb/vadv_ctrl_bench.sv
module vadv_ctrl_bench;
    localparam int Q_W = 64;

    logic clk = 1'b0;
    logic rst_n, start, step_en;
    logic signed [11:0] w_full, w_part;
    logic        [7:0]  d_est;
    logic signed [5:0]  q_full, q_part;
    logic        [1:0]  outcome;
    logic        [2:0]  shift_amt;
    logic signed [5:0]  q_sel;
    logic signed [21:0] w_next;
    logic signed [63:0] quotient;
    logic        [5:0]  bits_done;
    logic               done;
    logic        [15:0] cnt_full, cnt_part, cnt_none;

    int checks = 0, errors = 0;
    longint m_q;
    int m_bits, m_cf, m_cp, m_cn;
    bit finished = 0;

    always #2 clk = ~clk;

    vadv_ctrl u_vadv_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .step_en(step_en),
        .w_full(w_full), .w_part(w_part), .d_est(d_est),
        .q_full(q_full), .q_part(q_part), .outcome(outcome),
        .shift_amt(shift_amt), .q_sel(q_sel), .w_next(w_next),
        .quotient(quotient), .bits_done(bits_done), .done(done),
        .cnt_full(cnt_full), .cnt_part(cnt_part), .cnt_none(cnt_none));

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_code(input int w, input int d);
        int a = (w < 0) ? -w : w;
        if (a <= d)     return 1;
        if (a <= 4 * d) return 2;
        return 0;
    endfunction

    task automatic check_state(input string req);
        chk(quotient == m_q, {req, " quotient"}, quotient, m_q);
        chk(int'(bits_done) == m_bits, {req, " bits"}, bits_done, m_bits);
        chk(done == (m_bits >= 54), {req, " done"}, done, m_bits >= 54);
        chk(int'(cnt_full) == m_cf, {req, " cnt_full"}, cnt_full, m_cf);
        chk(int'(cnt_part) == m_cp, {req, " cnt_part"}, cnt_part, m_cp);
        chk(int'(cnt_none) == m_cn, {req, " cnt_none"}, cnt_none, m_cn);
    endtask

    task automatic do_step(input int wf, input int wp, input int d,
                           input int qf, input int qp, input bit en, input bit st);
        int code, dig, sh, res;
        @(negedge clk);
        w_full = 12'(wf); w_part = 12'(wp); d_est = 8'(d);
        q_full = 6'(qf); q_part = 6'(qp); step_en = en; start = st;
        #1;
        code = exp_code(wf, d);
        case (code)
            1: begin dig = qf; sh = 4; res = wf; end
            2: begin dig = qp; sh = 2; res = wp; end
            default: begin dig = (wf >= 0) ? 2 : -2; sh = 0; res = wf - dig * d; end
        endcase
        if (code == 1)      chk(outcome == 2'b01 && int'(q_sel) == dig, "R2 full", outcome, code);
        else if (code == 2) chk(outcome == 2'b10 && int'(q_sel) == dig, "R3 partial", outcome, code);
        else                chk(outcome == 2'b00 && int'(q_sel) == dig, "R4 none", q_sel, dig);
        chk(int'(shift_amt) == sh, "R2/R3/R4 shift", shift_amt, sh);
        chk(int'(w_next) == res, "R2/R3/R4 residual", w_next, res);
        if (st) begin
            m_q = 0; m_bits = 0; m_cf = 0; m_cp = 0; m_cn = 0;
        end else if (en && m_bits < 54) begin
            m_q = m_q * (longint'(1) << sh) + longint'(dig);
            m_bits += sh;
            if (code == 1) m_cf++; else if (code == 2) m_cp++; else m_cn++;
        end
        @(posedge clk);
        #1;
        if (st)          check_state("R8 start");
        else if (!en)    check_state("R6 idle");
        else if (done && m_bits >= 54) check_state("R7 done");
        else             check_state("R5 R9 accept");
    endtask

    initial begin
        #(4 * 150000);
        errors++; checks++;
        $display("FAIL watchdog actual=1 expected=0");
        if (!finished) $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 0; start = 0; step_en = 0;
        w_full = 0; w_part = 0; d_est = 8'd200; q_full = 0; q_part = 0;
        m_q = 0; m_bits = 0; m_cf = 0; m_cp = 0; m_cn = 0;
        repeat (3) @(posedge clk);
        #1;
        check_state("R1 reset");
        @(negedge clk); rst_n = 1;
        // Directed bound edges (R2, R3, R4)
        do_step(200, 5, 200, 7, 3, 1, 0);     // |w| == B: full
        do_step(-200, 5, 200, -7, 3, 1, 0);   // negative edge: full
        do_step(201, -9, 200, 7, -3, 1, 0);   // just above B: partial
        do_step(800, 11, 200, 7, 2, 1, 0);    // == 4B: partial
        do_step(-801, 0, 200, 7, 2, 1, 0);    // beyond 4B: none, +... digit -2
        do_step(801, 0, 200, 7, 2, 1, 0);     // beyond 4B positive: digit +2
        do_step(0, 0, 128, 15, 1, 1, 0);      // zero residual: full
        do_step(2047, 0, 128, 1, 1, 0, 0);    // R6: step low ignored
        do_step(-2048, 0, 255, 1, 1, 1, 0);   // most negative: none
        // Overshoot to done (R7): fulls until target
        for (int i = 0; i < 16; i++) do_step(10, 0, 200, -15, 0, 1, 0);
        do_step(10, 0, 200, 9, 0, 1, 0);      // step while done: ignored
        do_step(900, 0, 200, 9, 0, 1, 1);     // R8 start clears, beats step
        // Constrained random
        for (int n = 0; n < 3000; n++) begin
            int d = int'($urandom_range(128, 255));
            int wf = int'($urandom_range(0, 2400)) - 1200;
            int wp = int'($urandom_range(0, 1000)) - 500;
            int qf = int'($urandom_range(0, 30)) - 15;
            int qp = int'($urandom_range(0, 6)) - 3;
            bit en = ($urandom_range(0, 9) != 0);
            bit st = (m_bits >= 54) && ($urandom_range(0, 3) == 0);
            do_step(wf, wp, d, qf, qp, en, st);
        end
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
    end
endmodule